// File: doc/BRIEF.md
# Chained Transmit Buffer Sequencer

This block feeds one serial transmit channel from a pair of host-supplied buffers, A and B, used in turn. To hand a buffer to the block, the host writes a descriptor holding a start address, a byte count and a last-link flag. The write sets that buffer's owner bit. The block reads the buffer's bytes one at a time through a simple memory read port and presents each byte to the framer on a byte-wide handshake. When a buffer's bytes are all sent, the block clears its owner bit, which returns the buffer to the host, and then moves to the other buffer.

A frame can cover any number of buffers in the chain. Only a buffer whose last-link flag is set closes the frame. After that buffer, the block pulses a close request, and the framer then appends its check sequence and closing delimiter. Two interrupt pulses are available, each gated by its own enable: one when a buffer is returned, and one when a frame is complete. If the next buffer is not yet owned partway through a frame, the block stops and flags an underrun. It does not send stale data.

Top module: `txchain_seq`

## Requirements
- R1: During reset and in the first cycles after it, both owner flags are low and tx_valid, mem_req_valid, tx_close, irq_eob, irq_eof and underrun are all low.
- R2: A descriptor write (dsc_sel 0 = A, 1 = B) to a buffer whose owner flag is low loads the address, count and last-link flag and sets the owner flag in the next cycle. A descriptor write to a buffer that is already owned is ignored.
- R3: For each buffer, the block sends exactly dsc_cnt bytes in order. These are the memory data at the start address, start+1, and so on, with the address wrapping modulo 2^AW. tx_valid and tx_data stay unchanged until tx_ready accepts the byte.
- R4: After reset the first buffer used is A, and the buffers then strictly alternate. When a buffer is finished, its owner flag is cleared.
- R5: At most one memory read is outstanding at a time. mem_req_valid and mem_req_addr stay unchanged until mem_req_ready.
- R6: If the next buffer is not owned partway through a frame, underrun is high and nothing is requested or sent. Once that buffer is handed over, transmission resumes with its bytes.
- R7: tx_close pulses for exactly one cycle after the last byte of a buffer whose last-link flag is set. It never pulses for any other buffer.
- R8: irq_eob pulses once per returned buffer when eob_ie is 1. irq_eof pulses together with tx_close when eof_ie is 1. Both pulses appear in the same cycle for the closing buffer.
- R9: A buffer with count 0 is returned without any memory read. If its last-link flag is set, it still closes the frame.
- R10: Between frames, with no buffer owned, underrun stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eob_ie | input | 1 | Enable for the buffer-returned interrupt |
| eof_ie | input | 1 | Enable for the frame-complete interrupt |
| dsc_wr | input | 1 | Descriptor write strobe |
| dsc_sel | input | 1 | Descriptor target: 0 = A, 1 = B |
| dsc_addr | input | AW | Buffer start address |
| dsc_cnt | input | CW | Buffer byte count |
| dsc_last | input | 1 | Last-link flag: this buffer ends the frame |
| own_a | output | 1 | Buffer A is owned by the block |
| own_b | output | 1 | Buffer B is owned by the block |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Memory read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DW | Read data |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Framer accepts the byte |
| tx_data | output | DW | Transmit byte |
| tx_close | output | 1 | Request for check sequence and closing delimiter |
| irq_eob | output | 1 | Buffer-returned interrupt pulse |
| irq_eof | output | 1 | Frame-complete interrupt pulse |
| underrun | output | 1 | Stalled partway through a frame waiting for a buffer |

## Verification
The bench builds the block with AW=8 and CW=4. This makes every buffer length from 0 to 15 reachable in a single sweep, and with start addresses near 255 it also drives the address wrap. The memory model returns data that is an invertible function of the address, so a wrong address or a wrong byte order shows up in the data. Within the small count range, all four interrupt enable combinations and short two-buffer chains, including zero-length links, are swept.

// File: rtl/txchain_pkg.sv
package txchain_pkg;
  localparam int NUM_BUF = 2;

  typedef enum logic [2:0] {
    ST_LOAD  = 3'd0,
    ST_FETCH = 3'd1,
    ST_WAIT  = 3'd2,
    ST_SEND  = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/txchain_rst_sync.sv
module txchain_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/txchain_desc_bank.sv
module txchain_desc_bank
  import txchain_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       wr_sel,
  input  logic [AW-1:0]              wr_addr,
  input  logic [CW-1:0]              wr_cnt,
  input  logic                       wr_last,
  input  logic                       rel_en,
  input  logic                       rel_sel,
  output logic [NUM_BUF-1:0]         own,
  output logic [NUM_BUF-1:0][AW-1:0] base,
  output logic [NUM_BUF-1:0][CW-1:0] cnt,
  output logic [NUM_BUF-1:0]         last
);
  for (genvar g = 0; g < NUM_BUF; g++) begin : g_slot
    logic          own_q, own_d;
    logic          load_en;
    logic [AW-1:0] base_q;
    logic [CW-1:0] cnt_q;
    logic          last_q;

    // a write only lands in a slot the block does not hold
    assign load_en = wr_en && (wr_sel == 1'(g)) && !own_q;

    always_comb begin
      own_d = own_q;
      if (rel_en && (rel_sel == 1'(g))) own_d = 1'b0;
      if (load_en)                      own_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        own_q  <= 1'b0;
        base_q <= '0;
        cnt_q  <= '0;
        last_q <= 1'b0;
      end else begin
        own_q <= own_d;
        if (load_en) begin
          base_q <= wr_addr;
          cnt_q  <= wr_cnt;
          last_q <= wr_last;
        end
      end
    end

    assign own[g]  = own_q;
    assign base[g] = base_q;
    assign cnt[g]  = cnt_q;
    assign last[g] = last_q;
  end
endmodule

// File: rtl/txchain_ctrl.sv
module txchain_ctrl
  import txchain_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int DW = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       eob_ie,
  input  logic                       eof_ie,
  input  logic [NUM_BUF-1:0]         own,
  input  logic [NUM_BUF-1:0][AW-1:0] base,
  input  logic [NUM_BUF-1:0][CW-1:0] cnt,
  input  logic [NUM_BUF-1:0]         last,
  output logic                       rel_en,
  output logic                       rel_sel,
  output logic                       mem_req_valid,
  input  logic                       mem_req_ready,
  output logic [AW-1:0]              mem_req_addr,
  input  logic                       mem_rsp_valid,
  input  logic [DW-1:0]              mem_rsp_data,
  output logic                       tx_valid,
  input  logic                       tx_ready,
  output logic [DW-1:0]              tx_data,
  output logic                       tx_close,
  output logic                       irq_eob,
  output logic                       irq_eof,
  output logic                       underrun
);
  seq_state_t    state_q, state_d;
  logic          cur_q, cur_d;
  logic          infr_q, infr_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [CW-1:0] rem_q, rem_d;
  logic [DW-1:0] byte_q;
  logic          byte_en;
  logic          cnt_en;
  logic          done;

  assign byte_en = (state_q == ST_WAIT) && mem_rsp_valid;
  assign cnt_en  = ((state_q == ST_LOAD) && own[cur_q]) ||
                   ((state_q == ST_SEND) && tx_ready);

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    infr_d  = infr_q;
    ptr_d   = ptr_q;
    rem_d   = rem_q;
    unique case (state_q)
      ST_LOAD: begin
        if (own[cur_q]) begin
          ptr_d   = base[cur_q];
          rem_d   = cnt[cur_q];
          infr_d  = 1'b1;
          state_d = (cnt[cur_q] == '0) ? ST_DONE : ST_FETCH;
        end
      end
      ST_FETCH: if (mem_req_ready) state_d = ST_WAIT;
      ST_WAIT:  if (mem_rsp_valid) state_d = ST_SEND;
      ST_SEND: begin
        if (tx_ready) begin
          ptr_d   = ptr_q + 1'b1;
          rem_d   = rem_q - 1'b1;
          state_d = (rem_q == CW'(1)) ? ST_DONE : ST_FETCH;
        end
      end
      ST_DONE: begin
        cur_d   = ~cur_q;
        infr_d  = ~last[cur_q];
        state_d = ST_LOAD;
      end
      default: state_d = ST_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOAD;
      cur_q   <= 1'b0;
      infr_q  <= 1'b0;
      ptr_q   <= '0;
      rem_q   <= '0;
      byte_q  <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      infr_q  <= infr_d;
      if (cnt_en) begin
        ptr_q <= ptr_d;
        rem_q <= rem_d;
      end
      if (byte_en) byte_q <= mem_rsp_data;
    end
  end

  assign done          = (state_q == ST_DONE);
  assign rel_en        = done;
  assign rel_sel       = cur_q;
  assign mem_req_valid = (state_q == ST_FETCH);
  assign mem_req_addr  = ptr_q;
  assign tx_valid      = (state_q == ST_SEND);
  assign tx_data       = byte_q;
  assign tx_close      = done && last[cur_q];
  assign irq_eob       = done && eob_ie;
  assign irq_eof       = done && last[cur_q] && eof_ie;
  assign underrun      = (state_q == ST_LOAD) && infr_q && !own[cur_q];
endmodule

// File: rtl/txchain_seq.sv
module txchain_seq
  import txchain_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eob_ie,
  input  logic          eof_ie,
  input  logic          dsc_wr,
  input  logic          dsc_sel,
  input  logic [AW-1:0] dsc_addr,
  input  logic [CW-1:0] dsc_cnt,
  input  logic          dsc_last,
  output logic          own_a,
  output logic          own_b,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  output logic          tx_close,
  output logic          irq_eob,
  output logic          irq_eof,
  output logic          underrun
);
  logic                       rst_n_sync;
  logic [NUM_BUF-1:0]         own;
  logic [NUM_BUF-1:0][AW-1:0] base;
  logic [NUM_BUF-1:0][CW-1:0] cnt;
  logic [NUM_BUF-1:0]         last;
  logic                       rel_en;
  logic                       rel_sel;

  txchain_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  txchain_desc_bank #(.AW(AW), .CW(CW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (dsc_wr),
    .wr_sel  (dsc_sel),
    .wr_addr (dsc_addr),
    .wr_cnt  (dsc_cnt),
    .wr_last (dsc_last),
    .rel_en  (rel_en),
    .rel_sel (rel_sel),
    .own     (own),
    .base    (base),
    .cnt     (cnt),
    .last    (last)
  );

  txchain_ctrl #(.AW(AW), .CW(CW), .DW(DW)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n_sync),
    .eob_ie        (eob_ie),
    .eof_ie        (eof_ie),
    .own           (own),
    .base          (base),
    .cnt           (cnt),
    .last          (last),
    .rel_en        (rel_en),
    .rel_sel       (rel_sel),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .tx_data       (tx_data),
    .tx_close      (tx_close),
    .irq_eob       (irq_eob),
    .irq_eof       (irq_eof),
    .underrun      (underrun)
  );

  assign own_a = own[0];
  assign own_b = own[1];
endmodule

// File: rtl/txchain_chk.sv
module txchain_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dsc_wr,
  input logic          dsc_sel,
  input logic          own_a,
  input logic          own_b,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          mem_rsp_valid,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [DW-1:0] tx_data,
  input logic          tx_close,
  input logic          irq_eob,
  input logic          irq_eof,
  input logic          underrun
);
  logic       pend_q;
  logic [1:0] live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      live_q <= 2'b00;
    end else begin
      live_q <= {live_q[0], 1'b1};
      if (mem_req_valid && mem_req_ready) pend_q <= 1'b1;
      else if (mem_rsp_valid)             pend_q <= 1'b0;
    end
  end

  a_r5_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !mem_req_valid);

  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r3_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  a_r6_quiet_in_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (!tx_valid && !mem_req_valid && !tx_close));

  a_r7_close_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_close |=> !tx_close);

  a_r8_eof_with_close: assert property (@(posedge clk) disable iff (!rst_n)
    irq_eof |-> tx_close);

  a_r4_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_eob |=> !(own_a && own_b));

  a_r2_take_a: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q[1] && dsc_wr && !dsc_sel && !own_a) |=> own_a);
endmodule

bind txchain_seq txchain_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dsc_wr        (dsc_wr),
  .dsc_sel       (dsc_sel),
  .own_a         (own_a),
  .own_b         (own_b),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .tx_valid      (tx_valid),
  .tx_ready      (tx_ready),
  .tx_data       (tx_data),
  .tx_close      (tx_close),
  .irq_eob       (irq_eob),
  .irq_eof       (irq_eof),
  .underrun      (underrun)
);

// File: tb/tb_txchain_seq.sv
module tb_txchain_seq;
  localparam int AW = 8;
  localparam int CW = 4;
  localparam int DW = 8;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 150000;

  logic          clk;
  logic          rst_n;
  logic          eob_ie, eof_ie;
  logic          dsc_wr, dsc_sel, dsc_last;
  logic [AW-1:0] dsc_addr;
  logic [CW-1:0] dsc_cnt;
  logic          own_a, own_b;
  logic          mem_req_valid, mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid;
  logic [DW-1:0] mem_rsp_data;
  logic          tx_valid, tx_ready;
  logic [DW-1:0] tx_data;
  logic          tx_close, irq_eob, irq_eof, underrun;

  txchain_seq #(.AW(AW), .CW(CW), .DW(DW)) dut (.*);

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  // bench-side expectations
  logic [DW-1:0] exp_q[$];
  int            frame_q[$];
  int            frame_acc  = 0;
  int            frame_bytes = 0;
  logic          next_sel   = 1'b0;
  int            acc_bufs = 0, acc_frames = 0, acc_bytes = 0;
  int            got_eob = 0, got_eof = 0, got_close = 0, got_req = 0;
  logic          hold_tx = 1'b1;
  logic          pend = 1'b0;
  logic [AW-1:0] pend_addr;
  int            pend_wait = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] pat(logic [AW-1:0] a);
    return DW'(a * 8'd7 + 8'h3C);
  endfunction

  task automatic chk(string what, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG_CYCLES) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected at most %0d", cyc, WDOG_CYCLES);
      summary();
      $finish;
    end
  end

  // memory and framer model plus scoreboard, all at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      tx_ready      = 1'b0;
      pend          = 1'b0;
    end else begin
      mem_req_ready = (cyc % 3) != 1;
      tx_ready      = !hold_tx && ((cyc % 5) != 2);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (pend_wait == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = pat(pend_addr);
          pend          = 1'b0;
        end else pend_wait--;
      end
      if (mem_req_valid && mem_req_ready) begin
        pend      = 1'b1;
        pend_addr = mem_req_addr;
        pend_wait = cyc % 2;
        got_req++;
      end
      if (tx_valid && tx_ready) begin
        frame_bytes++;
        if (exp_q.size() == 0) chk("R3 unexpected byte", int'(tx_data), -1);
        else chk("R3 byte value", int'(tx_data), int'(exp_q.pop_front()));
      end
      if (irq_eob) got_eob++;
      if (irq_eof) begin
        got_eof++;
        chk("R8 frame irq coincides with close", int'(tx_close), 1);
      end
      if (tx_close) begin
        got_close++;
        if (frame_q.size() == 0) chk("R7 close without last link", 1, 0);
        else chk("R7 frame length at close", frame_bytes, frame_q.pop_front());
        frame_bytes = 0;
      end
    end
  end

  task automatic raw_write(logic sel, logic [AW-1:0] a, logic [CW-1:0] c, logic l);
    @(negedge clk);
    dsc_wr = 1'b1; dsc_sel = sel; dsc_addr = a; dsc_cnt = c; dsc_last = l;
    @(negedge clk);
    dsc_wr = 1'b0;
  endtask

  task automatic give(logic [AW-1:0] a, int c, logic l);
    for (int i = 0; i < c; i++) exp_q.push_back(pat(AW'(a + AW'(i))));
    frame_acc += c;
    acc_bufs++;
    acc_bytes += c;
    if (l) begin
      frame_q.push_back(frame_acc);
      frame_acc = 0;
      acc_frames++;
    end
    raw_write(next_sel, a, CW'(c), l);
    next_sel = ~next_sel;
  endtask

  task automatic wait_free(logic sel);
    while ((sel ? own_b : own_a) == 1'b1) @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || own_a || own_b) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic end_test(string tag);
    chk({tag, " R8 buffer irq count"}, got_eob, eob_ie ? acc_bufs : 0);
    chk({tag, " R8 frame irq count"}, got_eof, eof_ie ? acc_frames : 0);
    chk({tag, " R7 close count"}, got_close, acc_frames);
    chk({tag, " R9 memory reads"}, got_req, acc_bytes);
    chk({tag, " R4 owners released"}, int'({own_a, own_b}), 0);
    got_eob = 0; got_eof = 0; got_close = 0; got_req = 0;
    acc_bufs = 0; acc_frames = 0; acc_bytes = 0;
  endtask

  initial begin
    rst_n = 1'b0;
    eob_ie = 1'b1; eof_ie = 1'b1;
    dsc_wr = 1'b0; dsc_sel = 1'b0; dsc_addr = '0; dsc_cnt = '0; dsc_last = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk("R1 reset owners", int'({own_a, own_b}), 0);
    chk("R1 reset tx_valid", int'(tx_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 owners after reset", int'({own_a, own_b}), 0);
    chk("R1 requests after reset", int'(mem_req_valid), 0);
    chk("R1 tx_valid after reset", int'(tx_valid), 0);
    chk("R1 pulses after reset", int'({tx_close, irq_eob, irq_eof}), 0);
    chk("R10 idle underrun", int'(underrun), 0);
    hold_tx = 1'b0;

    // R4 R7: single-buffer frame, starts at A
    give(8'd16, 3, 1'b1);
    chk("R4 first buffer is A", int'(own_a), 1);
    drain();
    end_test("single");

    // R4: chain of three alternating links
    give(8'd40, 5, 1'b0);
    give(8'd60, 4, 1'b0);
    wait_free(1'b0);
    give(8'd80, 2, 1'b1);
    drain();
    end_test("chain");

    // R2: write to an owned buffer is ignored
    hold_tx = 1'b1;
    repeat (2) @(negedge clk);
    give(8'd100, 4, 1'b1);
    chk("R2 owner set by write", int'(own_a), 1);
    raw_write(1'b0, 8'd200, 4'd2, 1'b1);
    chk("R2 still owned", int'(own_a), 1);
    hold_tx = 1'b0;
    drain();
    end_test("ignored");

    // R6: stall partway through a frame
    give(8'd120, 3, 1'b0);
    wait_free(1'b1);
    repeat (6) @(negedge clk);
    chk("R6 underrun raised", int'(underrun), 1);
    chk("R6 no tx while stalled", int'(tx_valid), 0);
    chk("R6 no read while stalled", int'(mem_req_valid), 0);
    chk("R6 first link fully sent", exp_q.size(), 0);
    give(8'd130, 2, 1'b1);
    drain();
    chk("R6 underrun cleared", int'(underrun), 0);
    chk("R10 underrun low between frames", int'(underrun), 0);
    end_test("underrun");

    // R8: every enable combination
    for (int ie = 0; ie < 4; ie++) begin
      eob_ie = ie[0];
      eof_ie = ie[1];
      give(AW'(20 + ie * 16), 2, 1'b0);
      give(AW'(28 + ie * 16), 1, 1'b1);
      drain();
      end_test("enables");
    end
    eob_ie = 1'b1; eof_ie = 1'b1;

    // R3 R9: every length, addresses crossing the wrap
    for (int len = 0; len < 16; len++) begin
      give(AW'(245 + len * 3), len, 1'b1);
      drain();
      end_test("sweep");
    end

    // R9 R7: two-link frames with zero-length links
    for (int i = 0; i < 3; i++) begin
      for (int j = 0; j < 2; j++) begin
        give(AW'(50 + i * 10), (i == 2) ? 3 : i, 1'b0);
        give(AW'(250 + j), j * 2, 1'b1);
        drain();
        end_test("pairs");
      end
    end

    summary();
    $finish;
  end
endmodule